// File: doc/BRIEF.md
# Complementary PWM Dead-Time and Fault Guard

This block sits between a PWM timer and a pair of complementary output pins. It keeps an active dead-time value for each side. Software writes new values into buffers, and those buffers move into the active values only when the timer raises its update strobe while the lock-update input is low. A per-side valid flag shows which buffer holds fresh data. A dead-time generator delays the rising edge of each side by its active count. The two outputs are never high at once.

Fault protection watches a set of event inputs through a software mask. A masked event sets a sticky fault flag, which software clears by writing a one to it. On the same clock edge the block applies the selected action: it clears all output override enables, or it clears the direction bits of the pins of the enabled channels (which tri-states them), or it does nothing. Software uses a small register port. Writes are synchronous and reads are combinational.

Register map (3-bit address): 0 config (bits 1:0 fault action, bits 4+k channel k enable), 1 event mask, 2 status, 3 write-both buffer, 4 high-side buffer (reads the active high-side value), 5 low-side buffer (reads the active low-side value), 6 override enables, 7 direction bits.

Top module: `dtfault_ctrl`

## Requirements
- R1: Status (address 2) reads the fault flag in bit 2, the high-side buffer valid flag in bit 1 and the low-side buffer valid flag in bit 0. Bits 7:3 read zero.
- R2: A write to address 4 loads the high-side buffer and sets its valid flag. A write to address 5 does the same for the low side. A write to address 3 loads both buffers, sets both flags, and is stored so that address 3 reads it back.
- R3: On a clock with the update strobe high and lock-update low, each side whose valid flag is set copies its buffer into its active value (read at address 4 or 5) and clears its flag. A side whose flag is clear keeps its active value.
- R4: While lock-update is high, an update strobe leaves the active values and the valid flags unchanged.
- R5: An event on any input whose bit is set in the mask (address 1) sets the fault flag at the next clock edge. Events on unmasked inputs do not set it.
- R6: Writing status with bit 2 set clears the fault flag. Writing it with bit 2 clear has no effect. A masked event in the same cycle as the clear keeps the flag set.
- R7: Fault action 01 clears every override enable bit (address 6) on the edge that sets the flag. A software write to address 6 in that cycle loses.
- R8: Fault action 11 clears direction bits 2k and 2k+1 (address 7) for each channel k whose enable bit is set in config bit 4+k. The other direction bits are kept.
- R9: Fault actions 00 and 10 leave override enables and direction bits unchanged.
- R10: The high output is registered. It equals pwm_in AND (the number of consecutive high pwm_in samples before this edge, saturated at 255, is at least the active high-side count). The low output follows the same rule for the inverted pwm_in and the low-side count.
- R11: The high and low outputs are never high in the same cycle.
- R12: After synchronous reset, every register, flag and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| upd_strobe | input | 1 | Timer update condition |
| lock_upd | input | 1 | Timer lock-update, blocks buffer transfer |
| event_in | input | N_EV | Fault event inputs |
| pwm_in | input | 1 | PWM waveform from the timer |
| dt_hi_out | output | 1 | High-side output with dead time |
| dt_lo_out | output | 1 | Low-side output with dead time |
| ovr_en | output | 2*N_CH | Output override enables |
| pin_dir | output | 2*N_CH | Pin direction bits |

## Verification
A stale valid flag or a buffer that was lost shows up on the status read at once, and on the active-value read one clock after the next unlocked update. A wrong dead-time count shows up on the output edge within count+1 cycles of a pwm rise. A fault path that misses the mask or the action shows up as a wrong flag, override or direction value on the clock edge right after the event. The bench compares every port with a behavioural model on each clock, so any of these errors is reported in the first cycle where it appears.

// File: rtl/dtf_pkg.sv
// Package: shared address map and fault action encoding for the
// dead-time and fault guard. Assumes a 3-bit register address.
package dtf_pkg;
    typedef enum logic [2:0] {
        ADR_CFG    = 3'd0,
        ADR_MASK   = 3'd1,
        ADR_STAT   = 3'd2,
        ADR_BOTH   = 3'd3,
        ADR_HS     = 3'd4,
        ADR_LS     = 3'd5,
        ADR_OVEN   = 3'd6,
        ADR_DIR    = 3'd7
    } dtf_addr_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_OVR  = 2'b01,
        ACT_RSV  = 2'b10,
        ACT_DIR  = 2'b11
    } dtf_act_e;

    localparam int STAT_FAULT_BIT = 2;
    localparam int CFG_CH_LSB     = 4;
endpackage

// File: rtl/dtf_fault.sv
// Fault detector: masks the event inputs, keeps the sticky write-one-to-clear
// fault flag, and turns the selected action into clear masks for the
// override and direction registers. Assumes the events are already
// synchronous to clk.
module dtf_fault #(
    parameter int N_EV  = 8,
    parameter int N_CH  = 4,
    localparam int PIN_W = 2 * N_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EV-1:0]   event_in,
    input  logic [N_EV-1:0]   ev_mask,
    input  logic [1:0]        act_sel,
    input  logic [N_CH-1:0]   ch_en,
    input  logic              flag_clr,
    output logic              fault_flag,
    output logic              fault_hit,
    output logic              oven_clr,
    output logic [PIN_W-1:0]  dir_clr
);
    import dtf_pkg::*;

    // Purpose: detect a masked event in this cycle.
    assign fault_hit = |(event_in & ev_mask);

    // Purpose: sticky flag, set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_flag <= 1'b0;
        end else if (fault_hit) begin
            fault_flag <= 1'b1;
        end else if (flag_clr) begin
            fault_flag <= 1'b0;
        end
    end

    // Purpose: clear all override enables when that action is chosen.
    assign oven_clr = fault_hit && (dtf_act_e'(act_sel) == ACT_OVR);

    // Purpose: clear the pin pair of every enabled channel when that action is chosen.
    for (genvar k = 0; k < N_CH; k++) begin : g_dirclr
        assign dir_clr[2*k]   = fault_hit && (dtf_act_e'(act_sel) == ACT_DIR) && ch_en[k];
        assign dir_clr[2*k+1] = fault_hit && (dtf_act_e'(act_sel) == ACT_DIR) && ch_en[k];
    end
endmodule

// File: rtl/dtf_regs.sv
// Register bank: config, mask, write-both copy, dead-time buffers with
// valid flags, active dead-time values, override enables and direction
// bits. Buffered values move into the active values on an unlocked update.
// Assumes fault clears take priority over software writes.
module dtf_regs #(
    parameter int DW    = 8,
    parameter int N_EV  = 8,
    parameter int N_CH  = 4,
    localparam int PIN_W = 2 * N_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              upd_strobe,
    input  logic              lock_upd,
    input  logic              oven_clr,
    input  logic [PIN_W-1:0]  dir_clr,
    output logic [DW-1:0]     cfg_q,
    output logic [N_EV-1:0]   mask_q,
    output logic [DW-1:0]     both_q,
    output logic [DW-1:0]     act_hs,
    output logic [DW-1:0]     act_ls,
    output logic              hs_valid,
    output logic              ls_valid,
    output logic [PIN_W-1:0]  oven_q,
    output logic [PIN_W-1:0]  dir_q
);
    import dtf_pkg::*;

    logic [DW-1:0] buf_hs;
    logic [DW-1:0] buf_ls;
    logic          upd_ok;
    logic          wr_hs;
    logic          wr_ls;

    // Purpose: decode the write targets and the update gate.
    assign upd_ok = upd_strobe && !lock_upd;
    assign wr_hs  = wr_en && (dtf_addr_e'(wr_addr) == ADR_HS || dtf_addr_e'(wr_addr) == ADR_BOTH);
    assign wr_ls  = wr_en && (dtf_addr_e'(wr_addr) == ADR_LS || dtf_addr_e'(wr_addr) == ADR_BOTH);

    // Purpose: plain software registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '0;
            both_q <= '0;
        end else if (wr_en) begin
            case (dtf_addr_e'(wr_addr))
                ADR_CFG:  cfg_q  <= wr_data;
                ADR_MASK: mask_q <= wr_data[N_EV-1:0];
                ADR_BOTH: both_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // Purpose: high-side buffer, valid flag and active value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_hs   <= '0;
            hs_valid <= 1'b0;
            act_hs   <= '0;
        end else begin
            if (upd_ok && hs_valid) begin
                act_hs   <= buf_hs;
                hs_valid <= 1'b0;
            end
            if (wr_hs) begin
                buf_hs   <= wr_data;
                hs_valid <= 1'b1;
            end
        end
    end

    // Purpose: low-side buffer, valid flag and active value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_ls   <= '0;
            ls_valid <= 1'b0;
            act_ls   <= '0;
        end else begin
            if (upd_ok && ls_valid) begin
                act_ls   <= buf_ls;
                ls_valid <= 1'b0;
            end
            if (wr_ls) begin
                buf_ls   <= wr_data;
                ls_valid <= 1'b1;
            end
        end
    end

    // Purpose: override enables, fault clear overrides a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oven_q <= '0;
        end else if (oven_clr) begin
            oven_q <= '0;
        end else if (wr_en && dtf_addr_e'(wr_addr) == ADR_OVEN) begin
            oven_q <= wr_data[PIN_W-1:0];
        end
    end

    // Purpose: direction bits, fault clears the enabled pin pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_en && dtf_addr_e'(wr_addr) == ADR_DIR) begin
            dir_q <= wr_data[PIN_W-1:0] & ~dir_clr;
        end else begin
            dir_q <= dir_q & ~dir_clr;
        end
    end
endmodule

// File: rtl/dtf_deadgen.sv
// Dead-time generator for one side: the output rises only after the input
// has already been high for at least the given number of samples, and it
// falls at once with the input. The run counter saturates.
module dtf_deadgen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sig_in,
    input  logic [DW-1:0] dead_cnt,
    output logic          sig_out
);
    localparam logic [DW-1:0] RUN_MAX = '1;

    logic [DW-1:0] run_q;

    // Purpose: count consecutive high samples and gate the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            sig_out <= 1'b0;
        end else begin
            sig_out <= sig_in && (run_q >= dead_cnt);
            if (!sig_in) begin
                run_q <= '0;
            end else if (run_q != RUN_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtfault_ctrl.sv
// Top: complementary-output dead-time and fault guard. Connects the
// register bank, fault detector and two dead-time generators, and drives
// the combinational read mux. Assumes N_EV <= 8 and N_CH <= 4.
module dtfault_ctrl #(
    parameter int N_EV  = 8,
    parameter int N_CH  = 4,
    localparam int DW    = 8,
    localparam int PIN_W = 2 * N_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              upd_strobe,
    input  logic              lock_upd,
    input  logic [N_EV-1:0]   event_in,
    input  logic              pwm_in,
    output logic              dt_hi_out,
    output logic              dt_lo_out,
    output logic [PIN_W-1:0]  ovr_en,
    output logic [PIN_W-1:0]  pin_dir
);
    import dtf_pkg::*;

    logic [DW-1:0]    cfg_q;
    logic [N_EV-1:0]  mask_q;
    logic [DW-1:0]    both_q;
    logic [DW-1:0]    act_hs;
    logic [DW-1:0]    act_ls;
    logic             hs_valid;
    logic             ls_valid;
    logic             fault_flag;
    logic             fault_hit;
    logic             oven_clr;
    logic [PIN_W-1:0] dir_clr;
    logic             flag_clr;

    // Purpose: write-one-to-clear decode for the fault flag.
    assign flag_clr = wr_en && (dtf_addr_e'(wr_addr) == ADR_STAT) && wr_data[STAT_FAULT_BIT];

    dtf_regs #(.DW(DW), .N_EV(N_EV), .N_CH(N_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .upd_strobe(upd_strobe), .lock_upd(lock_upd), .oven_clr(oven_clr), .dir_clr(dir_clr),
        .cfg_q(cfg_q), .mask_q(mask_q), .both_q(both_q), .act_hs(act_hs), .act_ls(act_ls),
        .hs_valid(hs_valid), .ls_valid(ls_valid), .oven_q(ovr_en), .dir_q(pin_dir)
    );

    dtf_fault #(.N_EV(N_EV), .N_CH(N_CH)) u_fault (
        .clk(clk), .rst_n(rst_n), .event_in(event_in), .ev_mask(mask_q),
        .act_sel(cfg_q[1:0]), .ch_en(cfg_q[CFG_CH_LSB +: N_CH]), .flag_clr(flag_clr),
        .fault_flag(fault_flag), .fault_hit(fault_hit), .oven_clr(oven_clr), .dir_clr(dir_clr)
    );

    dtf_deadgen #(.DW(DW)) u_dead_hi (
        .clk(clk), .rst_n(rst_n), .sig_in(pwm_in), .dead_cnt(act_hs), .sig_out(dt_hi_out)
    );

    dtf_deadgen #(.DW(DW)) u_dead_lo (
        .clk(clk), .rst_n(rst_n), .sig_in(!pwm_in), .dead_cnt(act_ls), .sig_out(dt_lo_out)
    );

    // Purpose: combinational register read mux.
    always_comb begin
        rd_data = '0;
        case (dtf_addr_e'(rd_addr))
            ADR_CFG:  rd_data = cfg_q;
            ADR_MASK: rd_data[N_EV-1:0] = mask_q;
            ADR_STAT: rd_data = {5'b0, fault_flag, hs_valid, ls_valid};
            ADR_BOTH: rd_data = both_q;
            ADR_HS:   rd_data = act_hs;
            ADR_LS:   rd_data = act_ls;
            ADR_OVEN: rd_data[PIN_W-1:0] = ovr_en;
            ADR_DIR:  rd_data[PIN_W-1:0] = pin_dir;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dtf_checker.sv
// Checker: temporal properties of the dead-time and fault guard, bound
// to the top module. Assumes synchronous active-low reset.
module dtf_checker #(
    parameter int N_EV  = 8,
    parameter int PIN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_EV-1:0]  event_in,
    input logic [N_EV-1:0]  mask_q,
    input logic [7:0]       cfg_q,
    input logic             fault_flag,
    input logic             hs_valid,
    input logic             ls_valid,
    input logic [7:0]       act_hs,
    input logic [7:0]       act_ls,
    input logic             upd_strobe,
    input logic             lock_upd,
    input logic             wr_en,
    input logic             pwm_in,
    input logic             dt_hi_out,
    input logic             dt_lo_out,
    input logic [PIN_W-1:0] ovr_en
);
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|(event_in & mask_q)) |=> fault_flag); // R5
    AST_OVEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(event_in & mask_q)) && cfg_q[1:0] == 2'b01) |=> (ovr_en == '0)); // R7
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_upd && !wr_en) |=> ($stable(act_hs) && $stable(act_ls) && $stable(hs_valid) && $stable(ls_valid))); // R4
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe && !lock_upd && !wr_en) |=> (!hs_valid && !ls_valid)); // R3
    AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_in |=> !dt_hi_out); // R10
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(dt_hi_out && dt_lo_out)); // R11
endmodule

bind dtfault_ctrl dtf_checker #(.N_EV(N_EV), .PIN_W(PIN_W)) u_dtf_checker (
    .clk(clk), .rst_n(rst_n), .event_in(event_in), .mask_q(mask_q), .cfg_q(cfg_q),
    .fault_flag(fault_flag), .hs_valid(hs_valid), .ls_valid(ls_valid),
    .act_hs(act_hs), .act_ls(act_ls), .upd_strobe(upd_strobe), .lock_upd(lock_upd),
    .wr_en(wr_en), .pwm_in(pwm_in), .dt_hi_out(dt_hi_out), .dt_lo_out(dt_lo_out),
    .ovr_en(ovr_en)
);

// File: tb/test_dtfault_ctrl.sv
module test_dtfault_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_EV = 8;
    localparam int N_CH = 4;
    localparam int WDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       upd_strobe = 1'b0;
    logic       lock_upd = 1'b0;
    logic [7:0] event_in = '0;
    logic       pwm_in = 1'b0;
    logic       dt_hi_out;
    logic       dt_lo_out;
    logic [7:0] ovr_en;
    logic [7:0] pin_dir;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    dtfault_ctrl #(.N_EV(N_EV), .N_CH(N_CH)) i_dtfault_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .upd_strobe(upd_strobe), .lock_upd(lock_upd),
        .event_in(event_in), .pwm_in(pwm_in), .dt_hi_out(dt_hi_out), .dt_lo_out(dt_lo_out),
        .ovr_en(ovr_en), .pin_dir(pin_dir)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model state
    int m_cfg, m_mask, m_flag, m_hv, m_lv, m_both, m_bh, m_bl, m_ah, m_al;
    int m_oven, m_dir, m_runh, m_runl, m_hi, m_lo;

    function automatic int m_read(int a);
        case (a)
            0: return m_cfg;
            1: return m_mask;
            2: return m_flag * 4 + m_hv * 2 + m_lv;
            3: return m_both;
            4: return m_ah;
            5: return m_al;
            6: return m_oven;
            default: return m_dir;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_mask = 0; m_flag = 0; m_hv = 0; m_lv = 0; m_both = 0;
            m_bh = 0; m_bl = 0; m_ah = 0; m_al = 0; m_oven = 0; m_dir = 0;
            m_runh = 0; m_runl = 0; m_hi = 0; m_lo = 0;
        end else begin
            int hit, act, chmask, old_cfg, old_bh, old_bl, d;
            hit = ((int'(event_in) & m_mask) != 0);
            old_cfg = m_cfg; old_bh = m_bh; old_bl = m_bl;
            act = old_cfg & 3;
            chmask = 0;
            for (int k = 0; k < N_CH; k++)
                if ((old_cfg >> (4 + k)) & 1) chmask |= (3 << (2 * k));
            // dead time uses the active counts before this edge
            m_hi = (pwm_in && m_runh >= m_ah) ? 1 : 0;
            m_lo = (!pwm_in && m_runl >= m_al) ? 1 : 0;
            m_runh = pwm_in ? ((m_runh < 255) ? m_runh + 1 : 255) : 0;
            m_runl = !pwm_in ? ((m_runl < 255) ? m_runl + 1 : 255) : 0;
            if (upd_strobe && !lock_upd) begin
                if (m_hv) begin m_ah = old_bh; m_hv = 0; end
                if (m_lv) begin m_al = old_bl; m_lv = 0; end
            end
            if (wr_en) begin
                d = int'(wr_data);
                case (int'(wr_addr))
                    0: m_cfg = d;
                    1: m_mask = d;
                    2: if (d & 4) m_flag = 0;
                    3: begin m_both = d; m_bh = d; m_bl = d; m_hv = 1; m_lv = 1; end
                    4: begin m_bh = d; m_hv = 1; end
                    5: begin m_bl = d; m_lv = 1; end
                    6: m_oven = d;
                    default: m_dir = d;
                endcase
            end
            if (hit) begin
                m_flag = 1;
                if (act == 1) m_oven = 0;
                if (act == 3) m_dir = m_dir & ~chmask & 8'hFF;
            end
        end
    end

    task automatic chk(string req, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act_v, exp_v, $time);
        end
    endtask

    // Per-cycle comparison against the model
    task automatic cmp_all();
        string rq;
        case (int'(rd_addr))
            2: rq = "R1 status";
            3, 4, 5: rq = "R2/R3 dead-time read";
            6: rq = "R7 override read";
            7: rq = "R8 direction read";
            default: rq = "R5 config/mask read";
        endcase
        chk("R10 hi output", int'(dt_hi_out), m_hi);
        chk("R10 lo output", int'(dt_lo_out), m_lo);
        chk("R11 not both high", int'(dt_hi_out && dt_lo_out), 0);
        chk("R7 ovr_en", int'(ovr_en), m_oven);
        chk("R8 pin_dir", int'(pin_dir), m_dir);
        chk(rq, int'(rd_data), m_read(int'(rd_addr)));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, int exp_v);
        rd_addr = 3'(a);
        #1;
        chk(req, int'(rd_data), exp_v);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        // R12: state under reset
        for (int a = 0; a < 8; a++) rd_chk("R12 reset read", a, 0);
        chk("R12 reset outputs", int'({dt_hi_out, dt_lo_out, ovr_en, pin_dir}), 0);
        rst_n = 1'b1;
        cyc();
        // R1/R2: high-side buffer write
        wr(4, 5);
        rd_chk("R1 status hs valid", 2, 2);
        rd_chk("R2 active unchanged before update", 4, 0);
        // R4: locked update
        upd_strobe = 1'b1; lock_upd = 1'b1; cyc();
        upd_strobe = 1'b0; lock_upd = 1'b0;
        rd_chk("R4 flag kept under lock", 2, 2);
        rd_chk("R4 active kept under lock", 4, 0);
        // R3: unlocked update
        upd_strobe = 1'b1; cyc(); upd_strobe = 1'b0;
        rd_chk("R3 hs copied", 4, 5);
        rd_chk("R3 ls untouched", 5, 0);
        rd_chk("R3 flags cleared", 2, 0);
        // R2: write both
        wr(3, 3);
        rd_chk("R2 both flags", 2, 3);
        rd_chk("R2 both readback", 3, 3);
        upd_strobe = 1'b1; cyc(); upd_strobe = 1'b0;
        rd_chk("R3 hs from both", 4, 3);
        rd_chk("R3 ls from both", 5, 3);
        // R5/R7: override clear
        wr(0, 8'h11); wr(1, 8'h04); wr(6, 8'hFF); wr(7, 8'hFF);
        event_in = 8'h02; cyc(); event_in = 8'h00;
        rd_chk("R5 unmasked event ignored", 2, 0);
        chk("R5 override kept on unmasked", int'(ovr_en), 8'hFF);
        event_in = 8'h04; cyc(); event_in = 8'h00;
        rd_chk("R5 masked event sets flag", 2, 4);
        chk("R7 override cleared", int'(ovr_en), 0);
        chk("R7 direction kept", int'(pin_dir), 8'hFF);
        // R6: write-one-to-clear
        wr(2, 8'hFB);
        rd_chk("R6 write zero no effect", 2, 4);
        wr(2, 8'h04);
        rd_chk("R6 write one clears", 2, 0);
        event_in = 8'h04; wr(2, 8'h04); event_in = 8'h00;
        rd_chk("R6 set wins over clear", 2, 4);
        wr(2, 8'h04);
        // R8: direction clear for channels 0 and 2
        wr(0, 8'h53); wr(6, 8'hFF); wr(7, 8'hFF);
        event_in = 8'h04; cyc(); event_in = 8'h00;
        chk("R8 direction pairs cleared", int'(pin_dir), 8'hCC);
        chk("R8 override kept", int'(ovr_en), 8'hFF);
        // R9: reserved and none actions
        wr(0, 8'h52); wr(6, 8'hAA); wr(7, 8'h55);
        event_in = 8'h04; cyc(); event_in = 8'h00;
        chk("R9 action 10 override", int'(ovr_en), 8'hAA);
        chk("R9 action 10 direction", int'(pin_dir), 8'h55);
        wr(0, 8'h50);
        event_in = 8'h04; cyc(); event_in = 8'h00;
        chk("R9 action 00 override", int'(ovr_en), 8'hAA);
        chk("R9 action 00 direction", int'(pin_dir), 8'h55);
        // R10: dead time of 3 on the high side
        for (int i = 0; i < 6; i++) cyc();
        pwm_in = 1'b1;
        cyc(); cyc(); cyc();
        chk("R10 hi held low during dead time", int'(dt_hi_out), 0);
        cyc();
        chk("R10 hi follows after dead time", int'(dt_hi_out), 1);
        chk("R11 lo low while hi high", int'(dt_lo_out), 0);
        cyc(); pwm_in = 1'b0; cyc();
        chk("R10 hi falls with input", int'(dt_hi_out), 0);
        // Randomised phase, model compared every cycle
        for (int i = 0; i < 4000; i++) begin
            wr_en = (($urandom % 8) == 0);
            wr_addr = 3'($urandom);
            wr_data = 8'($urandom);
            if (wr_addr == 3'd3 || wr_addr == 3'd4 || wr_addr == 3'd5) wr_data = 8'($urandom % 6);
            rd_addr = 3'($urandom);
            upd_strobe = (($urandom % 5) == 0);
            lock_upd = (($urandom % 3) == 0);
            event_in = (($urandom % 10) == 0) ? 8'($urandom) : 8'h00;
            if (($urandom % 6) == 0) pwm_in = ~pwm_in;
            cyc();
        end
        wr_en = 1'b0; upd_strobe = 1'b0; event_in = '0;
        cyc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule